// File: doc/BRIEF.md
# SMBus Strap-Latched Address Selector

This block decides which 7-bit SMBus target address a monitoring device answers to. Two board-strapped pins, an enable strap and a select strap, decide between a default address (2Eh) and two alternates (2Ch and 2Dh). Those same pins are later shared with fan PWM and tachometer logic. The block samples the straps only inside the first bus transaction whose leading five address bits equal 01011b. Such a transaction cannot come from a glitch on an idle bus.

The block synchronizes SCL and SDA into the system clock domain and detects START and STOP conditions. It shifts in the address byte, most significant bit first, with the eighth bit taken as R/W. After that byte it raises an address-hit flag for the acknowledge stage. A mode output reports whether the shared pins still serve address selection (1) or have returned to their fan functions (0).

When a non-default address has been locked, the pins stay in selection mode. If a later transaction then finds the enable strap high at its fifth SCL clock, the address falls back to 2Eh and the pins are released. The system clock must run at least 8 times faster than SCL.

Top module: `smb_addr_strap`

## Requirements
- R1: After reset the current address is 2Eh, the pin-mode output is 1 (straps used for address selection) and the address-hit output is 0.
- R2: A first transaction with leading bits 01011b and the enable strap high locks address 2Eh. After its STOP the pin-mode output is 0.
- R3: A first transaction with leading bits 01011b, the enable strap low and the select strap low locks address 2Ch. The pin-mode output stays 1 after its STOP.
- R4: A first transaction with leading bits 01011b, the enable strap low and the select strap high locks address 2Dh. The pin-mode output stays 1.
- R5: A transaction whose first five address bits differ from 01011b leaves the block unlocked. The address stays 2Eh, the pin-mode output stays 1, and a later matching transaction still samples the straps.
- R6: Once an address is locked, changing the select strap, or pulling the enable strap low, does not change the current address.
- R7: With a non-default address locked, a later transaction that sees the enable strap high at its fifth SCL rising edge switches the address to 2Eh and the pin-mode output to 0. The address byte of that same transaction is then compared against 2Eh.
- R8: Address-hit rises after the eighth SCL rising edge of an address byte only when the first seven bits equal the current address. The R/W bit (eighth) is ignored, so a byte for 2Fh gives no hit.
- R9: Address-hit is cleared by a STOP and by a repeated START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_in | input | 1 | SMBus clock line (asynchronous) |
| sda_in | input | 1 | SMBus data line (asynchronous) |
| strap_en_in | input | 1 | Address enable strap (high selects default address) |
| strap_sel_in | input | 1 | Address select strap (low 2Ch, high 2Dh when enable low) |
| addr_hit | output | 1 | Address byte matched the current address |
| cur_addr | output | 7 | Address the device currently answers to |
| pins_strap_mode | output | 1 | 1: shared pins serve address selection; 0: returned to fan functions |

## Verification
Each strap combination is driven through a first matching transaction, and the addressed value shows which alternate was chosen. A transaction with a foreign prefix comes before a matching one, so an early lock is told apart from a correctly deferred one. Bytes that share the prefix but differ in the low bits, or only in R/W, separate a full 7-bit compare from a prefix-only compare. Strap changes after the lock, plus an enable-high transaction after a non-default lock, separate the frozen state from the fallback path.

// File: rtl/smb_strap_pkg.sv
package smb_strap_pkg;
  localparam int ADDR_W    = 7;
  localparam int PREFIX_W  = 5;
  localparam int BYTE_BITS = ADDR_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_DEFAULT = 7'h2E;
  localparam logic [ADDR_W-1:0] ADDR_ALT_LO  = 7'h2C;
  localparam logic [ADDR_W-1:0] ADDR_ALT_HI  = 7'h2D;
  localparam logic [PREFIX_W-1:0] ADDR_PREFIX = ADDR_DEFAULT[ADDR_W-1:ADDR_W-PREFIX_W];

  typedef enum logic [1:0] {
    LK_OPEN   = 2'd0,
    LK_PEND   = 2'd1,
    LK_LOCKED = 2'd2
  } lock_state_t;
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic en_in,
  input  logic sel_in,
  output logic sda_s,
  output logic en_s,
  output logic sel_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] chain [SYNC_STAGES];
  logic scl_q, sda_q;
  logic scl_s;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= {1'b1, 1'b1, 1'b1, 1'b0};
          else        chain[s] <= {scl_in, sda_in, en_in, sel_in};
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= {1'b1, 1'b1, 1'b1, 1'b0};
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign scl_s = chain[SYNC_STAGES-1][3];
  assign sda_s = chain[SYNC_STAGES-1][2];
  assign en_s  = chain[SYNC_STAGES-1][1];
  assign sel_s = chain[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

  assert_start_stop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/smb_addr_shift.sv
module smb_addr_shift
  import smb_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              bit5_stb,
  output logic [PREFIX_W-1:0] prefix_bits,
  output logic              addr_hit
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              hit_q, hit_d;
  logic              take_bit;

  always_comb begin
    take_bit = scl_rise && act_q && (cnt_q < CNT_W'(BYTE_BITS));
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    hit_d = hit_q;
    if (start_det) begin
      act_d = 1'b1;
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (stop_det) begin
      act_d = 1'b0;
      hit_d = 1'b0;
    end else if (take_bit) begin
      sh_d  = {sh_q[ADDR_W-2:0], sda_s};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(BYTE_BITS - 1))
        hit_d = (sh_q == cur_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      hit_q <= hit_d;
    end
  end

  assign bit5_stb    = take_bit && (cnt_q == CNT_W'(PREFIX_W - 1));
  assign prefix_bits = {sh_q[PREFIX_W-2:0], sda_s};
  assign addr_hit    = hit_q;

  assert_hit_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> (cnt_q == CNT_W'(BYTE_BITS)));
  assert_hit_clear_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || start_det) |=> !hit_q);
endmodule

// File: rtl/smb_strap_ctrl.sv
module smb_strap_ctrl
  import smb_strap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit5_stb,
  input  logic [PREFIX_W-1:0] prefix_bits,
  input  logic                stop_det,
  input  logic                en_s,
  input  logic                sel_s,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                strap_mode
);
  lock_state_t       st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              mode_q, mode_d;
  logic [ADDR_W-1:0] strap_pick;

  always_comb begin
    if (en_s)       strap_pick = ADDR_DEFAULT;
    else if (sel_s) strap_pick = ADDR_ALT_HI;
    else            strap_pick = ADDR_ALT_LO;
  end

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    mode_d = mode_q;
    unique case (st_q)
      LK_OPEN: begin
        if (bit5_stb && (prefix_bits == ADDR_PREFIX)) begin
          addr_d = strap_pick;
          st_d   = LK_PEND;
        end
      end
      LK_PEND: begin
        if (stop_det) begin
          st_d   = LK_LOCKED;
          mode_d = (addr_q != ADDR_DEFAULT);
        end
      end
      LK_LOCKED: begin
        if (mode_q && bit5_stb && en_s) begin
          addr_d = ADDR_DEFAULT;
          mode_d = 1'b0;
        end
      end
      default: st_d = LK_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_OPEN;
      addr_q <= ADDR_DEFAULT;
      mode_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign cur_addr   = addr_q;
  assign strap_mode = mode_q;

  assert_unlocked_strap_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != LK_LOCKED) |-> mode_q);
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_LOCKED) |=> (st_q == LK_LOCKED));
  assert_released_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_LOCKED && !mode_q) |=> ($stable(addr_q) && !mode_q));
  assert_fallback_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_LOCKED && $fell(mode_q)) |-> (addr_q == ADDR_DEFAULT));
endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap
  import smb_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              strap_en_in,
  input  logic              strap_sel_in,
  output logic              addr_hit,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              pins_strap_mode
);
  logic sda_s, en_s, sel_s, scl_rise, start_det, stop_det;
  logic bit5_stb;
  logic [PREFIX_W-1:0] prefix_bits;

  smb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .en_in     (strap_en_in),
    .sel_in    (strap_sel_in),
    .sda_s     (sda_s),
    .en_s      (en_s),
    .sel_s     (sel_s),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_addr_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .scl_rise    (scl_rise),
    .sda_s       (sda_s),
    .cur_addr    (cur_addr),
    .bit5_stb    (bit5_stb),
    .prefix_bits (prefix_bits),
    .addr_hit    (addr_hit)
  );

  smb_strap_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit5_stb    (bit5_stb),
    .prefix_bits (prefix_bits),
    .stop_det    (stop_det),
    .en_s        (en_s),
    .sel_s       (sel_s),
    .cur_addr    (cur_addr),
    .strap_mode  (pins_strap_mode)
  );
endmodule

// File: tb/smb_addr_strap_bench.sv
`timescale 1ns/1ps
module smb_addr_strap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, sen = 1'b1, ssel = 1'b0;
  logic       hit;
  logic [6:0] addr;
  logic       smode;
  int total = 0;
  int bad = 0;
  localparam time Q = 40ns;

  always #2.5 clk = ~clk;

  smb_addr_strap u_smb_addr_strap (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .strap_en_in(sen), .strap_sel_in(ssel),
    .addr_hit(hit), .cur_addr(addr), .pins_strap_mode(smode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; #Q scl = 1'b1; #Q sda = 1'b0; #Q scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda = 1'b0; #Q scl = 1'b1; #Q sda = 1'b1; #Q;
  endtask

  task automatic bus_bit(input logic b);
    scl = 1'b0; sda = b; #Q scl = 1'b1; #(2*Q) scl = 1'b0; #Q;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) bus_bit(a[i]);
    bus_bit(rw);
    bus_bit(1'b1);
  endtask

  task automatic xfer(input logic [6:0] a);
    bus_start(); send_addr(a, 1'b0); bus_stop();
  endtask

  task automatic t_reset();
    do_reset();
    check(addr == 7'h2E, "R1 addr", addr, 'h2E);
    check(smode == 1'b1, "R1 mode", smode, 1);
    check(hit == 1'b0, "R1 hit", hit, 0);
  endtask

  task automatic t_default();
    sen = 1'b1; ssel = 1'b0; do_reset();
    bus_start(); send_addr(7'h2E, 1'b0);
    check(hit == 1'b1, "R2/R8 hit 2E", hit, 1);
    check(addr == 7'h2E, "R2 addr", addr, 'h2E);
    bus_stop();
    check(hit == 1'b0, "R9 hit cleared by stop", hit, 0);
    check(smode == 1'b0, "R2 pins released", smode, 0);
    sen = 1'b0; ssel = 1'b0;
    bus_start(); send_addr(7'h2C, 1'b0);
    check(hit == 1'b0, "R6 no hit 2C after default lock", hit, 0);
    bus_stop();
    check(addr == 7'h2E, "R6 addr frozen", addr, 'h2E);
  endtask

  task automatic t_alt_lo();
    sen = 1'b0; ssel = 1'b0; do_reset();
    xfer(7'h50);
    check(addr == 7'h2E, "R5 addr unchanged", addr, 'h2E);
    check(smode == 1'b1, "R5 mode", smode, 1);
    bus_start(); send_addr(7'h2C, 1'b0);
    check(hit == 1'b1, "R3 hit 2C", hit, 1);
    bus_stop();
    check(addr == 7'h2C, "R3 addr", addr, 'h2C);
    check(smode == 1'b1, "R3 mode kept", smode, 1);
    ssel = 1'b1;
    bus_start(); send_addr(7'h2D, 1'b0);
    check(hit == 1'b0, "R6 no hit 2D", hit, 0);
    bus_stop();
    check(addr == 7'h2C, "R6 addr kept 2C", addr, 'h2C);
  endtask

  task automatic t_alt_hi_and_revert();
    sen = 1'b0; ssel = 1'b1; do_reset();
    bus_start(); send_addr(7'h2D, 1'b1);
    check(hit == 1'b1, "R4 hit 2D", hit, 1);
    bus_start();
    check(hit == 1'b0, "R9 hit cleared by repeated start", hit, 0);
    bus_stop();
    check(addr == 7'h2D, "R4 addr", addr, 'h2D);
    check(smode == 1'b1, "R4 mode", smode, 1);
    sen = 1'b1;
    bus_start(); send_addr(7'h2E, 1'b0);
    check(hit == 1'b1, "R7 hit 2E in fallback transaction", hit, 1);
    check(addr == 7'h2E, "R7 addr", addr, 'h2E);
    check(smode == 1'b0, "R7 mode", smode, 0);
    bus_stop();
  endtask

  task automatic t_compare();
    sen = 1'b1; ssel = 1'b0; do_reset();
    bus_start(); send_addr(7'h2F, 1'b0);
    check(hit == 1'b0, "R8 no hit 2F", hit, 0);
    bus_stop();
    bus_start(); send_addr(7'h2E, 1'b1);
    check(hit == 1'b1, "R8 hit with rw=1", hit, 1);
    bus_stop();
  endtask

  initial begin
    t_reset();
    t_default();
    t_alt_lo();
    t_alt_hi_and_revert();
    t_compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule